// File: doc/BRIEF.md
# Line-Doubled Monochrome Scanline Serializer

This block turns a packed one-bit-per-pixel framebuffer into a serial pixel stream for a raster display. Each display line starts with a start strobe from an external sync generator, which also supplies the current line number. The block checks that number against a programmable top-blanking offset. If the line falls inside the active window, it fetches the row's 16-bit words over a simple synchronous read port and shifts them out one bit per clock, least significant bit first.

Every stored row is shown on two consecutive display lines. A row pointer steps by one stride on every second active line and returns to the framebuffer base on the first blank line. After the row's own words, the block always sends one extra all-zero word so that the output settles back to blank before the horizontal retrace. Words are fetched two cycles before they are needed, so the bits of a line follow each other with no gap.

Top module: `dbl_line_serializer`

## Requirements
- R1: After reset, scanBusy, memRdEn and pixOut are 0, and the vertical offset register holds 25.
- R2: A scanStart sampled with lineNum = N starts a scan only when offset <= N < offset + 2*(HEIGHT-1). For any other N, no read is issued and scanBusy stays 0.
- R3: When line numbers arrive consecutively from the first active line, line N shows row (N - offset) >> 1. The reads of word k use address FB_BASE + row*STRIDE + k, so each row appears on two lines in a row.
- R4: The first inactive line after an active one returns the row pointer to FB_BASE, so the next active line shows row 0.
- R5: Call cycle 1 the cycle after the edge that samples scanStart. Bit b of word k appears on pixOut in cycle 3 + 16k + b. Bit 0 comes first and there is no gap between words.
- R6: After the WIDTH pixels, 16 more cycles carry 0 on pixOut with scanBusy high. scanBusy is high in cycles 1 to 16*(WIDTH/16+1)+2 and low in the cycle after.
- R7: pixOut is 0 whenever scanBusy is 0 and in cycles 1 and 2 of a scan.
- R8: An active line issues exactly WIDTH/16 reads, one per memRdEn cycle, never in two adjacent cycles, and only while scanBusy is high. The read data is taken one cycle after memRdEn.
- R9: A scanStart that arrives while scanBusy is high, outside the last pixel cycle, is ignored. The stream in progress does not change and the row pointer does not move.
- R10: A scanStart in the last pixel cycle of a scan is accepted, and the next line starts with no idle cycle.
- R11: cfgWr loads cfgOffset into the offset register. A scanStart in the same cycle is judged against the previous offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanStart | input | 1 | One-cycle line strobe from the sync generator |
| lineNum | input | LINE_W | Current display line number |
| cfgWr | input | 1 | Load strobe for the vertical offset |
| cfgOffset | input | LINE_W | New vertical offset value |
| memRdEn | output | 1 | Framebuffer read request |
| memAddr | output | ADDR_W | Framebuffer word address |
| memRdData | input | 16 | Read data, valid the cycle after memRdEn |
| pixOut | output | 1 | Serial pixel, 0 when blank |
| scanBusy | output | 1 | High while a line is being scanned |

## Verification
Two of the block's functions can fall in the same cycle. The first pair is the last pixel of one line and the strobe that opens the next. The bench raises scanStart in exactly that final cycle and requires the new line to start at once, with its own row and with the previous line's stream intact. The second pair is an offset write and a line strobe. The bench issues both in one cycle and requires that line to be judged against the old window, with the next line judged against the new one. A stray strobe placed in the middle of a line checks the boundary between these cases: the bench confirms that the stream does not change and that the following line still shows the expected row.

// File: rtl/scan_ser_pkg.sv
package scan_ser_pkg;

  localparam int unsigned WORD_BITS = 16;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic rdIssue;
    logic load;
    logic loadZero;
    logic shift;
    logic clear;
    logic rowAdvance;
    logic rowReset;
  } scanCtl_t;

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_ser_pkg::*;
#(
  parameter int WIDTH      = 320,
  parameter int HEIGHT     = 240,
  parameter int LINE_W     = 10,
  parameter int DEF_OFFSET = 25,
  parameter int IDX_W      = $clog2(WIDTH / 16 + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scanStart,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              cfgWr,
  input  logic [LINE_W-1:0] cfgOffset,
  output scanCtl_t          ctl,
  output logic [IDX_W-1:0]  rdWordIdx,
  output logic              busy
);

  localparam int WORDS_ROW = WIDTH / 16;
  localparam int WORDS_OUT = WORDS_ROW + 1;
  localparam int LAST_T    = 16 * WORDS_OUT + 2;
  localparam int T_W       = $clog2(LAST_T + 1);
  localparam int LW2       = LINE_W + 2;

  logic [LINE_W-1:0] offReg;
  logic              inBlank;
  logic              busyQ;
  logic [T_W-1:0]    tCnt;

  logic [LW2-1:0] lineExt, offExt, endExt, relLine;
  logic           lineAct, lastBit, accept;
  logic [3:0]     phase;
  logic [T_W-1:0] wordNo;

  // active window test
  assign lineExt = LW2'(lineNum);
  assign offExt  = LW2'(offReg);
  assign endExt  = offExt + LW2'(2 * (HEIGHT - 1));
  assign relLine = lineExt - offExt;
  assign lineAct = (lineExt >= offExt) && (lineExt < endExt);

  assign lastBit = busyQ && (tCnt == T_W'(LAST_T));
  assign accept  = scanStart && (!busyQ || lastBit);
  assign phase   = tCnt[3:0];
  assign wordNo  = tCnt >> 4;
  assign busy    = busyQ;

  always_comb begin
    ctl       = '0;
    rdWordIdx = '0;
    if (busyQ) begin
      if (phase == 4'd0 && wordNo >= T_W'(1) && wordNo < T_W'(WORDS_ROW)) begin
        ctl.rdIssue = 1'b1;
        rdWordIdx   = IDX_W'(wordNo);
      end
      if (phase == 4'd2 && wordNo < T_W'(WORDS_OUT)) begin
        ctl.load     = 1'b1;
        ctl.loadZero = (wordNo >= T_W'(WORDS_ROW));
      end else begin
        ctl.shift = 1'b1;
      end
    end
    if (accept) begin
      if (lineAct) begin
        ctl.rowAdvance = !inBlank && !relLine[0];
        ctl.clear      = 1'b1;
        ctl.rdIssue    = 1'b1;
        ctl.load       = 1'b0;
        ctl.shift      = 1'b0;
        rdWordIdx      = '0;
      end else begin
        ctl.rowReset = !inBlank;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReg  <= LINE_W'(DEF_OFFSET);
      inBlank <= 1'b1;
      busyQ   <= 1'b0;
      tCnt    <= '0;
    end else begin
      if (cfgWr) offReg <= cfgOffset;
      if (accept) begin
        inBlank <= !lineAct;
        busyQ   <= lineAct;
        tCnt    <= lineAct ? T_W'(1) : '0;
      end else if (lastBit) begin
        busyQ <= 1'b0;
        tCnt  <= '0;
      end else if (busyQ) begin
        tCnt <= tCnt + T_W'(1);
      end
    end
  end

  // R6: the scan counter never runs past the trailing word
  assert_scan_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (tCnt >= T_W'(1) && tCnt <= T_W'(LAST_T)));

  // R9: a strobe in mid-line leaves the busy state untouched
  assert_ignore_midline_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !lastBit && scanStart) |=> busyQ);

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_ser_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int STRIDE  = 20,
  parameter int FB_BASE = 0,
  parameter int IDX_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanCtl_t          ctl,
  input  logic [IDX_W-1:0]  rdWordIdx,
  input  logic              busy,
  input  logic [15:0]       memRdData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              pixOut
);

  logic [ADDR_W-1:0]    rowPtr;
  logic [ADDR_W-1:0]    nextRow;
  logic [WORD_BITS-1:0] shiftReg;

  always_comb begin
    if (ctl.rowReset)        nextRow = ADDR_W'(FB_BASE);
    else if (ctl.rowAdvance) nextRow = rowPtr + ADDR_W'(STRIDE);
    else                     nextRow = rowPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowPtr   <= ADDR_W'(FB_BASE);
      memRdEn  <= 1'b0;
      memAddr  <= '0;
      shiftReg <= '0;
    end else begin
      rowPtr  <= nextRow;
      memRdEn <= ctl.rdIssue;
      if (ctl.rdIssue) memAddr <= nextRow + ADDR_W'(rdWordIdx);
      if (ctl.clear)       shiftReg <= '0;
      else if (ctl.load)   shiftReg <= ctl.loadZero ? '0 : memRdData;
      else if (ctl.shift)  shiftReg <= {1'b0, shiftReg[WORD_BITS-1:1]};
    end
  end

  assign pixOut = shiftReg[0];

  // R7: no pixel leaves the block outside a scan
  assert_blank_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !pixOut);

  // R8: reads happen only inside a scan and never back to back
  assert_read_in_scan_R8: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);
  assert_read_spacing_R8: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R4: a reset strobe sends the pointer home
  assert_row_home_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rowReset |=> (rowPtr == ADDR_W'(FB_BASE)));

  // R3: an advance moves the pointer by exactly one stride
  assert_row_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rowAdvance |=> (rowPtr == $past(rowPtr) + ADDR_W'(STRIDE)));

endmodule

// File: rtl/dbl_line_serializer.sv
module dbl_line_serializer
  import scan_ser_pkg::*;
#(
  parameter int WIDTH      = 320,
  parameter int HEIGHT     = 240,
  parameter int STRIDE     = 20,
  parameter int FB_BASE    = 0,
  parameter int ADDR_W     = 16,
  parameter int LINE_W     = 10,
  parameter int DEF_OFFSET = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scanStart,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              cfgWr,
  input  logic [LINE_W-1:0] cfgOffset,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [15:0]       memRdData,
  output logic              pixOut,
  output logic              scanBusy
);

  localparam int IDX_W = $clog2(WIDTH / 16 + 1);

  scanCtl_t         ctl;
  logic [IDX_W-1:0] rdWordIdx;
  logic             busy;

  scan_ctrl #(
    .WIDTH(WIDTH), .HEIGHT(HEIGHT), .LINE_W(LINE_W),
    .DEF_OFFSET(DEF_OFFSET), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .scanStart(scanStart), .lineNum(lineNum),
    .cfgWr(cfgWr), .cfgOffset(cfgOffset),
    .ctl(ctl), .rdWordIdx(rdWordIdx), .busy(busy)
  );

  scan_datapath #(
    .ADDR_W(ADDR_W), .STRIDE(STRIDE), .FB_BASE(FB_BASE), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdWordIdx(rdWordIdx), .busy(busy),
    .memRdData(memRdData), .memRdEn(memRdEn), .memAddr(memAddr),
    .pixOut(pixOut)
  );

  assign scanBusy = busy;

endmodule

// File: tb/dbl_line_serializer_bench.sv
`timescale 1ns/1ps
module dbl_line_serializer_bench;

  localparam int WIDTH  = 32;
  localparam int HEIGHT = 4;
  localparam int STRIDE = 3;
  localparam int BASE   = 8;
  localparam int WR     = WIDTH / 16;
  localparam int LAST   = 16 * (WR + 1) + 2;

  logic       clk = 0;
  logic       rstN = 0;
  logic       scanStart = 0;
  logic [9:0] lineNum = '0;
  logic       cfgWr = 0;
  logic [9:0] cfgOffset = '0;
  logic       memRdEn;
  logic [7:0] memAddr;
  logic [15:0] memRdData = '0;
  logic       pixOut;
  logic       scanBusy;

  int errors = 0;
  int checks = 0;
  int rdCnt = 0;
  int rdLog [4];
  bit pending = 0;

  always #4 clk = ~clk;

  dbl_line_serializer #(
    .WIDTH(WIDTH), .HEIGHT(HEIGHT), .STRIDE(STRIDE), .FB_BASE(BASE),
    .ADDR_W(8), .LINE_W(10), .DEF_OFFSET(25)
  ) u_dbl_line_serializer (
    .clk(clk), .rstN(rstN), .scanStart(scanStart), .lineNum(lineNum),
    .cfgWr(cfgWr), .cfgOffset(cfgOffset), .memRdEn(memRdEn),
    .memAddr(memAddr), .memRdData(memRdData), .pixOut(pixOut),
    .scanBusy(scanBusy)
  );

  function automatic logic [15:0] memWord(input int a);
    return 16'((a * 947 + 311) ^ 32'h9C5A);
  endfunction

  // framebuffer model: data one cycle after the request
  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= memWord(int'(memAddr));
      if (rdCnt < 4) rdLog[rdCnt] = int'(memAddr);
      rdCnt = rdCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // runs one line; called at a negedge, returns at a negedge
  task automatic runLine(input int line, input bit expAct, input int row,
                         input int strayAt, input int chainLine, input string req);
    int mism = 0;
    int badT = -1;
    int badAct = 0;
    int badExp = 0;
    if (!pending) begin
      scanStart = 1; lineNum = 10'(line);
      @(negedge clk);
    end
    scanStart = 0;
    pending = 0;
    rdCnt = 0;
    for (int t = 1; t <= LAST; t++) begin
      int p = t - 3;
      bit eb = 0;
      if (expAct && p >= 0 && p < WIDTH)
        eb = memWord(BASE + row * STRIDE + p / 16)[p % 16];
      if (pixOut !== eb || scanBusy !== expAct) begin
        if (mism == 0) begin
          badT = t; badAct = {scanBusy, pixOut}; badExp = {expAct, eb};
        end
        mism++;
      end
      if (t == strayAt) begin scanStart = 1; lineNum = 10'd99; end
      else if (t == strayAt + 1) scanStart = 0;
      if (t == LAST && chainLine >= 0) begin
        scanStart = 1; lineNum = 10'(chainLine); pending = 1;
      end
      @(negedge clk);
    end
    check(mism == 0, req, $sformatf("line %0d stream {busy,pix} at cycle %0d", line, badT),
          badAct, badExp);
    check(rdCnt == (expAct ? WR : 0), "R8", $sformatf("line %0d read count", line),
          rdCnt, expAct ? WR : 0);
    if (expAct && rdCnt >= 2) begin
      check(rdLog[0] == BASE + row * STRIDE, "R3", $sformatf("line %0d word0 addr", line),
            rdLog[0], BASE + row * STRIDE);
      check(rdLog[1] == rdLog[0] + 1, "R3", $sformatf("line %0d word1 addr", line),
            rdLog[1], rdLog[0] + 1);
    end
    if (chainLine < 0)
      check(scanBusy == 0 && pixOut == 0, "R6", $sformatf("line %0d idle after end", line),
            {scanBusy, pixOut}, 0);
  endtask

  task automatic testReset();
    check(scanBusy == 0, "R1", "busy in reset", scanBusy, 0);
    check(memRdEn == 0, "R1", "read in reset", memRdEn, 0);
    check(pixOut == 0, "R1", "pix in reset", pixOut, 0);
  endtask

  // default offset 25: window is 25..30, rows 0..2
  task automatic testDefaultWindow();
    runLine(23, 0, 0, -1, -1, "R2");
    runLine(24, 0, 0, -1, -1, "R1");
    runLine(25, 1, 0, -1, 26, "R5");
    runLine(26, 1, 0, -1, -1, "R10");
    runLine(27, 1, 1, 10, -1, "R9");
    runLine(28, 1, 1, -1, 29, "R3");
    runLine(29, 1, 2, -1, -1, "R10");
    runLine(30, 1, 2, -1, -1, "R6");
    runLine(31, 0, 0, -1, -1, "R2");
  endtask

  task automatic testPointerHome();
    runLine(24, 0, 0, -1, -1, "R7");
    runLine(25, 1, 0, -1, -1, "R4");
    runLine(26, 1, 0, -1, -1, "R4");
  endtask

  task automatic testOffsetCollide();
    runLine(40, 0, 0, -1, -1, "R4");
    scanStart = 1; lineNum = 10'd25; cfgWr = 1; cfgOffset = 10'd5;
    @(negedge clk);
    cfgWr = 0;
    pending = 1;
    runLine(25, 1, 0, -1, -1, "R11");
    runLine(26, 0, 0, -1, -1, "R11");
    runLine(4, 0, 0, -1, -1, "R11");
    runLine(5, 1, 0, -1, -1, "R11");
    runLine(6, 1, 0, -1, -1, "R3");
    runLine(7, 1, 1, -1, -1, "R3");
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    check(scanBusy == 0 && pixOut == 0, "R1", "idle after reset", {scanBusy, pixOut}, 0);
    testDefaultWindow();
    testPointerHome();
    testOffsetCollide();
    finishRun();
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

endmodule